// File: doc/BRIEF.md
# Mixed-Width True Dual-Port RAM

This block is a synthesizable behavioural model of a 9216-bit true dual-port RAM. Two fully independent ports, A and B, share one storage array. Each port has its own clock, clock enable, write enable, output reset, 13-bit address, write data and read data. The read data width of each port is fixed by parameter at 1, 2, 4 or 9 bits, so one port can write whole 9-bit words while the other reads or writes narrow slices of the same words.

The storage is 1024 words of 9 bits. The upper ten address bits select a word. The lowest three address bits select a slice of the word's eight data bits. The ninth bit of each word is reachable only through a 9-bit port.

Each port has a parameter that sets what its read output shows during its own write. A single parameter makes both ports' output resets either synchronous or asynchronous. A parameter image sets the array contents. The active-low input `rst_ni` loads that image and clears both read outputs. The block has no output pipeline register: read data appears after the clock edge that captures the address.

Top module: `mixed_dpram`

## Requirements
- R1: The word index is `addr[12:3]`. A 9-bit port ignores `addr[2:0]`. A 4-bit port uses `addr[2]` to select data bits [3:0] (value 0) or [7:4] (value 1). A 2-bit port selects bits [2k+1:2k] with k = `addr[2:1]`. A 1-bit port selects data bit `addr[2:0]`. Address bits below the selected slice are ignored.
- R2: Both ports see one array. Data written through a port of one width is read back through the other port at its own width, and a narrow write changes only its own slice of the word.
- R3: A read takes one clock edge. Read data changes only at the port's rising clock edge after the address is captured, and the address is not decoded combinationally to the output.
- R4: While a port's clock enable is low (and its reset is low), a clock edge neither writes the array nor changes that port's read output.
- R5: In write mode `WM_KEEP`, the writing port's read output keeps its previous value across the write cycle.
- R6: In write mode `WM_PASS`, the writing port's read output shows the newly written data after the write edge.
- R7: In write mode `WM_OLD`, the writing port's read output shows the contents that the addressed slice held before the write.
- R8: With `RM_SYNC`, a high port reset clears that port's read output to zero at the next rising edge of its clock, whether or not the clock enable is high. Before that edge the output does not change. A write requested in the same cycle still takes place.
- R9: With `RM_ASYNC`, a high port reset clears that port's read output to zero immediately, with no clock edge.
- R10: While `rst_ni` is low, and after it is released until the first read, both read outputs are zero.
- R11: `rst_ni` loads the array from `INIT_IMAGE`. Word n occupies bits [9n+8:9n], so word 0 is in the least significant bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low power-up reset; loads the image and clears outputs |
| clk_a_i | input | 1 | Port A clock |
| ce_a_i | input | 1 | Port A clock enable |
| we_a_i | input | 1 | Port A write enable |
| rst_a_i | input | 1 | Port A output reset, active high |
| addr_a_i | input | 13 | Port A address |
| wdata_a_i | input | WIDTH_A | Port A write data |
| rdata_a_o | output | WIDTH_A | Port A read data |
| clk_b_i | input | 1 | Port B clock |
| ce_b_i | input | 1 | Port B clock enable |
| we_b_i | input | 1 | Port B write enable |
| rst_b_i | input | 1 | Port B output reset, active high |
| addr_b_i | input | 13 | Port B address |
| wdata_b_i | input | WIDTH_B | Port B write data |
| rdata_b_o | output | WIDTH_B | Port B read data |

## Verification
The bench targets the points where the two port widths meet.

- A 9-bit word written with nonzero low address bits is read back in 2-bit lanes. A wrong lane decode would return the wrong pair of bits or fold the ninth bit into the data.
- A narrow write-through write is followed by a full-word read. A port that clobbered neighbouring lanes, or lost bit 8, would show a different word.
- Each write mode is checked on the write cycle itself. A wrong mode would show held, new or old data where another is expected.
- Both reset modes are sampled between clock edges. A synchronous reset that clears early, or an asynchronous reset that waits for a clock, is caught. A write issued under synchronous reset is read back afterwards, which catches a design that drops it.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  localparam int unsigned WORD_W     = 9;
  localparam int unsigned LANE_W     = 8;
  localparam int unsigned LANE_SEL_W = 3;

  typedef enum logic [1:0] {
    WM_KEEP = 2'd0,  // output held during own write
    WM_PASS = 2'd1,  // output shows new data
    WM_OLD  = 2'd2   // output shows prior contents
  } wr_mode_e;

  typedef enum logic {
    RM_SYNC  = 1'b0,
    RM_ASYNC = 1'b1
  } rst_mode_e;
endpackage

// File: rtl/dpram_addr_dec.sv
module dpram_addr_dec
  import dpram_pkg::*;
#(
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned DW      = 9,
  localparam int unsigned WORD_AW = ADDR_W - LANE_SEL_W
) (
  input  logic [ADDR_W-1:0]     addr_i,
  output logic [WORD_AW-1:0]    word_o,
  output logic [LANE_SEL_W-1:0] lane_off_o
);
  assign word_o = addr_i[ADDR_W-1:LANE_SEL_W];

  // Bit offset of the slice inside the 8-bit data part of the word
  if (DW == 9) begin : g_w9
    logic [2:0] unused_lo;
    assign unused_lo  = addr_i[2:0];
    assign lane_off_o = '0;
  end else if (DW == 4) begin : g_w4
    logic [1:0] unused_lo;
    assign unused_lo  = addr_i[1:0];
    assign lane_off_o = {addr_i[2], 2'b00};
  end else if (DW == 2) begin : g_w2
    logic unused_lo;
    assign unused_lo  = addr_i[0];
    assign lane_off_o = {addr_i[2:1], 1'b0};
  end else begin : g_w1
    assign lane_off_o = addr_i[2:0];
  end
endmodule

// File: rtl/dpram_port.sv
module dpram_port
  import dpram_pkg::*;
#(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned DW          = 9,
  parameter wr_mode_e    WMODE       = WM_KEEP,
  parameter rst_mode_e   RMODE       = RM_SYNC,
  parameter bit          HOLDS_IMAGE = 1'b0,
  parameter int unsigned MEM_BITS    = (2 ** (ADDR_W - LANE_SEL_W)) * WORD_W,
  parameter logic [MEM_BITS-1:0] INIT_IMAGE = '0,
  localparam int unsigned WORD_AW = ADDR_W - LANE_SEL_W,
  localparam int unsigned BASE_W  = $clog2(MEM_BITS)
) (
  input  logic                rst_ni,
  input  logic                clk_i,
  input  logic                ce_i,
  input  logic                we_i,
  input  logic                rst_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic [MEM_BITS-1:0] peer_bank_i,
  output logic [MEM_BITS-1:0] own_bank_o,
  output logic [DW-1:0]       rdata_o
);
  logic [WORD_AW-1:0]    word_idx;
  logic [LANE_SEL_W-1:0] lane_off;

  dpram_addr_dec #(
    .ADDR_W(ADDR_W),
    .DW    (DW)
  ) u_dec (
    .addr_i    (addr_i),
    .word_o    (word_idx),
    .lane_off_o(lane_off)
  );

  logic [BASE_W-1:0] base;
  logic [BASE_W-1:0] wr_pos;
  assign base   = BASE_W'(word_idx) * BASE_W'(WORD_W);
  assign wr_pos = base + BASE_W'(lane_off);

  logic [MEM_BITS-1:0] bank_q;
  logic [WORD_W-1:0]   peer_word;
  logic [WORD_W-1:0]   live_word;
  logic [DW-1:0]       peer_slice;
  logic [DW-1:0]       live_slice;

  // Stored value = own bank XOR peer bank; each bank has a single writer
  assign peer_word = peer_bank_i[base +: WORD_W];
  assign live_word = bank_q[base +: WORD_W] ^ peer_word;

  if (DW == WORD_W) begin : g_full
    logic [LANE_SEL_W-1:0] unused_off;
    assign unused_off = lane_off;
    assign peer_slice = peer_word;
    assign live_slice = live_word;
  end else begin : g_lane
    logic [LANE_W-1:0] peer_data;
    logic [LANE_W-1:0] live_data;
    logic              unused_par;
    assign peer_data  = peer_word[LANE_W-1:0];
    assign live_data  = live_word[LANE_W-1:0];
    assign unused_par = peer_word[WORD_W-1] ^ live_word[WORD_W-1];
    assign peer_slice = peer_data[lane_off +: DW];
    assign live_slice = live_data[lane_off +: DW];
  end

  logic wr_fire;
  assign wr_fire = ce_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= HOLDS_IMAGE ? INIT_IMAGE : '0;
    end else if (wr_fire) begin
      bank_q[wr_pos +: DW] <= wdata_i ^ peer_slice;
    end
  end

  assign own_bank_o = bank_q;

  // Read output register
  logic          arst;
  logic          srst;
  logic [DW-1:0] rd_next;
  logic [DW-1:0] rdata_q;

  assign arst = (RMODE == RM_ASYNC) & rst_i;
  assign srst = (RMODE == RM_SYNC)  & rst_i;

  always_comb begin
    rd_next = rdata_q;
    if (!we_i) begin
      rd_next = live_slice;
    end else begin
      unique case (WMODE)
        WM_PASS: rd_next = wdata_i;
        WM_OLD:  rd_next = live_slice;
        default: rd_next = rdata_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni or posedge arst) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (arst) begin
      rdata_q <= '0;
    end else if (srst) begin
      rdata_q <= '0;
    end else if (ce_i) begin
      rdata_q <= rd_next;
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/mixed_dpram.sv
module mixed_dpram
  import dpram_pkg::*;
#(
  parameter int unsigned ADDR_W   = 13,
  parameter int unsigned WIDTH_A  = 9,
  parameter int unsigned WIDTH_B  = 9,
  parameter wr_mode_e    WMODE_A  = WM_KEEP,
  parameter wr_mode_e    WMODE_B  = WM_KEEP,
  parameter rst_mode_e   RST_MODE = RM_SYNC,
  localparam int unsigned WORDS    = 2 ** (ADDR_W - LANE_SEL_W),
  localparam int unsigned MEM_BITS = WORDS * WORD_W,
  parameter logic [MEM_BITS-1:0] INIT_IMAGE = '0
) (
  input  logic               rst_ni,
  input  logic               clk_a_i,
  input  logic               ce_a_i,
  input  logic               we_a_i,
  input  logic               rst_a_i,
  input  logic [ADDR_W-1:0]  addr_a_i,
  input  logic [WIDTH_A-1:0] wdata_a_i,
  output logic [WIDTH_A-1:0] rdata_a_o,
  input  logic               clk_b_i,
  input  logic               ce_b_i,
  input  logic               we_b_i,
  input  logic               rst_b_i,
  input  logic [ADDR_W-1:0]  addr_b_i,
  input  logic [WIDTH_B-1:0] wdata_b_i,
  output logic [WIDTH_B-1:0] rdata_b_o
);
  logic [MEM_BITS-1:0] bank_a;
  logic [MEM_BITS-1:0] bank_b;

  // Port A carries the initial image; port B's bank starts at zero
  dpram_port #(
    .ADDR_W     (ADDR_W),
    .DW         (WIDTH_A),
    .WMODE      (WMODE_A),
    .RMODE      (RST_MODE),
    .HOLDS_IMAGE(1'b1),
    .MEM_BITS   (MEM_BITS),
    .INIT_IMAGE (INIT_IMAGE)
  ) u_port_a (
    .rst_ni     (rst_ni),
    .clk_i      (clk_a_i),
    .ce_i       (ce_a_i),
    .we_i       (we_a_i),
    .rst_i      (rst_a_i),
    .addr_i     (addr_a_i),
    .wdata_i    (wdata_a_i),
    .peer_bank_i(bank_b),
    .own_bank_o (bank_a),
    .rdata_o    (rdata_a_o)
  );

  dpram_port #(
    .ADDR_W     (ADDR_W),
    .DW         (WIDTH_B),
    .WMODE      (WMODE_B),
    .RMODE      (RST_MODE),
    .HOLDS_IMAGE(1'b0),
    .MEM_BITS   (MEM_BITS),
    .INIT_IMAGE (INIT_IMAGE)
  ) u_port_b (
    .rst_ni     (rst_ni),
    .clk_i      (clk_b_i),
    .ce_i       (ce_b_i),
    .we_i       (we_b_i),
    .rst_i      (rst_b_i),
    .addr_i     (addr_b_i),
    .wdata_i    (wdata_b_i),
    .peer_bank_i(bank_a),
    .own_bank_o (bank_b),
    .rdata_o    (rdata_b_o)
  );
endmodule

// File: rtl/mixed_dpram_chk.sv
module mixed_dpram_chk
  import dpram_pkg::*;
#(
  parameter int unsigned ADDR_W   = 13,
  parameter int unsigned WIDTH_A  = 9,
  parameter int unsigned WIDTH_B  = 9,
  parameter wr_mode_e    WMODE_A  = WM_KEEP,
  parameter wr_mode_e    WMODE_B  = WM_KEEP,
  parameter rst_mode_e   RST_MODE = RM_SYNC
) (
  input logic               rst_ni,
  input logic               clk_a_i,
  input logic               ce_a_i,
  input logic               we_a_i,
  input logic               rst_a_i,
  input logic [WIDTH_A-1:0] wdata_a_i,
  input logic [WIDTH_A-1:0] rdata_a_o,
  input logic               clk_b_i,
  input logic               ce_b_i,
  input logic               we_b_i,
  input logic               rst_b_i,
  input logic [WIDTH_B-1:0] wdata_b_i,
  input logic [WIDTH_B-1:0] rdata_b_o
);
  // Port A
  a_r4_hold_a: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (!ce_a_i && !rst_a_i) |=> (rst_a_i || $stable(rdata_a_o)));
  a_r5_keep_a: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (WMODE_A == WM_KEEP && ce_a_i && we_a_i && !rst_a_i) |=> (rst_a_i || $stable(rdata_a_o)));
  a_r6_pass_a: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (WMODE_A == WM_PASS && ce_a_i && we_a_i && !rst_a_i) |=> (rst_a_i || rdata_a_o == $past(wdata_a_i)));
  a_r8_clear_a: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    rst_a_i |=> (rdata_a_o == '0));
  a_r9_async_a: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (RST_MODE == RM_ASYNC && rst_a_i) |-> (rdata_a_o == '0));

  // Port B
  a_r4_hold_b: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (!ce_b_i && !rst_b_i) |=> (rst_b_i || $stable(rdata_b_o)));
  a_r5_keep_b: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (WMODE_B == WM_KEEP && ce_b_i && we_b_i && !rst_b_i) |=> (rst_b_i || $stable(rdata_b_o)));
  a_r6_pass_b: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (WMODE_B == WM_PASS && ce_b_i && we_b_i && !rst_b_i) |=> (rst_b_i || rdata_b_o == $past(wdata_b_i)));
  a_r8_clear_b: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    rst_b_i |=> (rdata_b_o == '0));
  a_r9_async_b: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (RST_MODE == RM_ASYNC && rst_b_i) |-> (rdata_b_o == '0));
endmodule

bind mixed_dpram mixed_dpram_chk #(
  .ADDR_W  (ADDR_W),
  .WIDTH_A (WIDTH_A),
  .WIDTH_B (WIDTH_B),
  .WMODE_A (WMODE_A),
  .WMODE_B (WMODE_B),
  .RST_MODE(RST_MODE)
) u_chk (
  .rst_ni   (rst_ni),
  .clk_a_i  (clk_a_i),
  .ce_a_i   (ce_a_i),
  .we_a_i   (we_a_i),
  .rst_a_i  (rst_a_i),
  .wdata_a_i(wdata_a_i),
  .rdata_a_o(rdata_a_o),
  .clk_b_i  (clk_b_i),
  .ce_b_i   (ce_b_i),
  .we_b_i   (we_b_i),
  .rst_b_i  (rst_b_i),
  .wdata_b_i(wdata_b_i),
  .rdata_b_o(rdata_b_o)
);

// File: tb/tb_mixed_dpram.sv
`timescale 1ns/1ps
module tb_mixed_dpram;
  import dpram_pkg::*;

  localparam int unsigned MEM_BITS = 1024 * 9;
  localparam logic [MEM_BITS-1:0] IMG2 = {{(MEM_BITS-18){1'b0}}, 9'h03C, 9'h1A5};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // dut: A 9-bit keep, B 2-bit pass, synchronous reset
  logic ce_a1, we_a1, rs_a1, ce_b1, we_b1, rs_b1;
  logic [12:0] ad_a1, ad_b1;
  logic [8:0] wd_a1, rd_a1;
  logic [1:0] wd_b1, rd_b1;

  mixed_dpram #(
    .WIDTH_A(9), .WIDTH_B(2), .WMODE_A(WM_KEEP), .WMODE_B(WM_PASS), .RST_MODE(RM_SYNC)
  ) dut (
    .rst_ni(rst_ni),
    .clk_a_i(clk), .ce_a_i(ce_a1), .we_a_i(we_a1), .rst_a_i(rs_a1),
    .addr_a_i(ad_a1), .wdata_a_i(wd_a1), .rdata_a_o(rd_a1),
    .clk_b_i(clk), .ce_b_i(ce_b1), .we_b_i(we_b1), .rst_b_i(rs_b1),
    .addr_b_i(ad_b1), .wdata_b_i(wd_b1), .rdata_b_o(rd_b1)
  );

  // dut_async: A 4-bit old, B 1-bit keep, asynchronous reset, preloaded
  logic ce_a2, we_a2, rs_a2, ce_b2, we_b2, rs_b2;
  logic [12:0] ad_a2, ad_b2;
  logic [3:0] wd_a2, rd_a2;
  logic [0:0] wd_b2, rd_b2;

  mixed_dpram #(
    .WIDTH_A(4), .WIDTH_B(1), .WMODE_A(WM_OLD), .WMODE_B(WM_KEEP), .RST_MODE(RM_ASYNC),
    .INIT_IMAGE(IMG2)
  ) dut_async (
    .rst_ni(rst_ni),
    .clk_a_i(clk), .ce_a_i(ce_a2), .we_a_i(we_a2), .rst_a_i(rs_a2),
    .addr_a_i(ad_a2), .wdata_a_i(wd_a2), .rdata_a_o(rd_a2),
    .clk_b_i(clk), .ce_b_i(ce_b2), .we_b_i(we_b2), .rst_b_i(rs_b2),
    .addr_b_i(ad_b2), .wdata_b_i(wd_b2), .rdata_b_o(rd_b2)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // Inputs change at negedge; outputs checked at the following negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R10 dut A after reset", 32'(rd_a1), 0);
    check("R10 dut B after reset", 32'(rd_b1), 0);
    check("R10 async A after reset", 32'(rd_a2), 0);
    check("R10 async B after reset", 32'(rd_b2), 0);
  endtask

  task automatic t_keep_write();
    ce_a1 = 1; we_a1 = 1; ad_a1 = 13'd47; wd_a1 = 9'h15A;
    step();
    check("R5 keep output on write", 32'(rd_a1), 0);
    we_a1 = 0; ad_a1 = 13'd40;
    #5;
    check("R3 no change before edge", 32'(rd_a1), 0);
    step();
    check("R1 R3 word read low bits ignored", 32'(rd_a1), 32'h15A);
  endtask

  task automatic t_cross_width();
    ce_b1 = 1; we_b1 = 0; ad_b1 = 13'd46;
    step();
    check("R2 lane3 of word5", 32'(rd_b1), 1);
    ad_b1 = 13'd41;
    step();
    check("R1 lane0 low bit ignored", 32'(rd_b1), 2);
  endtask

  task automatic t_pass_write();
    we_b1 = 1; ad_b1 = 13'd42; wd_b1 = 2'b01;
    step();
    check("R6 pass output on write", 32'(rd_b1), 1);
    we_b1 = 0;
    step();
    check("R2 full word after lane write", 32'(rd_a1), 32'h156);
  endtask

  task automatic t_ce_low();
    ce_a1 = 0; we_a1 = 1; ad_a1 = 13'd40; wd_a1 = 9'h000;
    step();
    check("R4 output held with ce low", 32'(rd_a1), 32'h156);
    ce_a1 = 1; we_a1 = 0;
    step();
    check("R4 no write with ce low", 32'(rd_a1), 32'h156);
  endtask

  task automatic t_sync_reset();
    ce_b1 = 0; rs_b1 = 1;
    #5;
    check("R8 no clear before edge", 32'(rd_b1), 1);
    step();
    check("R8 clear with ce low", 32'(rd_b1), 0);
    rs_b1 = 0; ce_b1 = 1;
    rs_a1 = 1; we_a1 = 1; ad_a1 = 13'd80; wd_a1 = 9'h0FF;
    step();
    check("R8 clear during write", 32'(rd_a1), 0);
    rs_a1 = 0; we_a1 = 0;
    step();
    check("R8 write under reset stored", 32'(rd_a1), 32'h0FF);
  endtask

  task automatic t_init();
    ce_a2 = 1; ad_a2 = 13'd0;
    step();
    check("R11 word0 low nibble", 32'(rd_a2), 5);
    ad_a2 = 13'd4;
    step();
    check("R11 R1 word0 high nibble", 32'(rd_a2), 32'hA);
    ad_a2 = 13'd8;
    step();
    check("R11 word1 low nibble", 32'(rd_a2), 32'hC);
    ce_b2 = 1; ad_b2 = 13'd10;
    step();
    check("R1 bit2 of word1", 32'(rd_b2), 1);
    ad_b2 = 13'd8;
    step();
    check("R1 bit0 of word1", 32'(rd_b2), 0);
    ad_b2 = 13'd7;
    step();
    check("R11 bit7 of word0", 32'(rd_b2), 1);
  endtask

  task automatic t_old_write();
    we_a2 = 1; ad_a2 = 13'd0; wd_a2 = 4'h3;
    step();
    check("R7 old data on write", 32'(rd_a2), 5);
    we_a2 = 0;
    step();
    check("R7 new data stored", 32'(rd_a2), 3);
  endtask

  task automatic t_keep_narrow();
    we_b2 = 1; ad_b2 = 13'd10; wd_b2 = 1'b0;
    step();
    check("R5 1-bit keep on write", 32'(rd_b2), 1);
    we_b2 = 0;
    step();
    check("R5 1-bit write stored", 32'(rd_b2), 0);
    ad_a2 = 13'd8;
    step();
    check("R2 nibble after bit write", 32'(rd_a2), 8);
  endtask

  task automatic t_async_reset();
    rs_a2 = 1;
    #2;
    check("R9 immediate clear", 32'(rd_a2), 0);
    step();
    check("R9 held through edge", 32'(rd_a2), 0);
    rs_a2 = 0;
    #5;
    check("R9 stays zero until edge", 32'(rd_a2), 0);
    step();
    check("R3 read after release", 32'(rd_a2), 8);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    {ce_a1, we_a1, rs_a1, ce_b1, we_b1, rs_b1} = '0;
    {ce_a2, we_a2, rs_a2, ce_b2, we_b2, rs_b2} = '0;
    ad_a1 = '0; ad_b1 = '0; ad_a2 = '0; ad_b2 = '0;
    wd_a1 = '0; wd_b1 = '0; wd_a2 = '0; wd_b2 = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    step();
    t_reset();
    t_keep_write();
    t_cross_width();
    t_pass_write();
    t_ce_low();
    t_sync_reset();
    t_init();
    t_old_write();
    t_keep_narrow();
    t_async_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule